// File: doc/BRIEF.md
# Multi-Queue DMA Event Scheduler

This block sits between DMA event detection and transfer-request issue. Each of 64 channels can raise an event, and the event carries a 2-bit type tag. The event is held in a pending register. Each cycle, the lowest-numbered pending channel whose target queue has room is selected. That event is appended to one of several transfer-request FIFOs. A programmable per-channel map picks the FIFO.

Every FIFO serves exactly one transfer controller. The head of a FIFO is issued to its controller only when that controller is ready. When several controllers can accept, the lowest-numbered queue goes first, and at most one request leaves the block per cycle. If an event targets an empty queue whose controller is both idle and ready, and no queued entry is being issued that cycle, the event goes straight to the controller. It is then never stored or counted. Software-visible views give each queue's fill level and any of its entries. The block emits only the identity of the dequeued event, as a type and a channel number.

Top module: `evt_queue_sched`

## Requirements
- R1: A channel's pending bit (`pend`) sets on the clock edge after its `evt_set` bit is high. It stays set until that event is enqueued or bypassed, and it clears on the same edge.
- R2: Of the pending channels whose target queue holds fewer than 16 entries, the lowest-numbered channel is taken. At most one channel is taken per cycle.
- R3: Each channel has a 2-bit queue field, written through `map_we`/`map_ch`/`map_q`. A taken event goes to the queue named by its channel's field.
- R4: A queue holds at most 16 entries. An event whose queue is full stays pending and is taken once an entry has been removed.
- R5: Entries leave each queue in the order in which they entered it.
- R6: A queue's head is removed only in a cycle in which that queue's `tc_ready` bit is high. The resulting request appears only on the matching `req_valid` bit, on the following edge.
- R7: When several non-empty queues have ready controllers, the lowest-numbered queue is served. At most one `req_valid` bit is high in any cycle.
- R8: A taken event is bypassed when all of the following hold in that cycle: its queue is empty, that controller's `tc_idle` and `tc_ready` are both high, and no queue is being dequeued. A bypassed event is issued on the next edge and never changes `q_count`. If `tc_idle` is low, the event is queued instead.
- R9: An entry is `{type[1:0], channel[5:0]}`, with type 00 manual, 01 hardware event, 10 chained and 11 auto-triggered. `view_entry` shows entry `view_idx` (0 = head) of queue `view_q` one cycle later. `view_vld` is high when that index is below the queue's fill level.
- R10: `q_count` holds a 5-bit fill level per queue, from 0 to 16, with queue n in bits [5n+4:5n].
- R11: A synchronous active-high `rst` empties all queues, clears all pending bits and request outputs, and sets every queue-map field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 64 | One-cycle event trigger per channel |
| evt_type | input | 128 | 2-bit type per channel, latched with its trigger |
| map_we | input | 1 | Write strobe for the queue map |
| map_ch | input | 6 | Channel whose map field is written |
| map_q | input | 2 | Queue number written |
| tc_ready | input | 4 | Controller n can accept a request |
| tc_idle | input | 4 | Controller n has no work in progress |
| req_valid | output | 4 | One-cycle request to controller n |
| req_type | output | 8 | Event type of the request, 2 bits per controller |
| req_ch | output | 24 | Channel of the request, 6 bits per controller |
| view_q | input | 2 | Queue selected for entry view |
| view_idx | input | 4 | Entry index from the head |
| view_entry | output | 8 | Viewed entry |
| view_vld | output | 1 | Viewed index lies within the fill level |
| q_count | output | 20 | Fill level per queue |
| pend | output | 64 | Pending-event register |

## Verification
The tests use several trigger patterns:
- A lone trigger to an idle, ready controller. This separates bypass from queuing.
- The same lone trigger with the controller busy. This shows the event is stored and counted instead.
- Two channels raised in the same cycle. This shows which channel wins arbitration and the order of the entries.
- Triggers spread across two queues, with both controllers ready at once. This shows the cross-queue priority and the one-request-per-cycle limit.
- Seventeen channels aimed at one stalled queue. This drives the 16-entry limit and shows the overflow event waiting in the pending register until a single dequeue frees space.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  localparam int TYPE_W = 2;

  typedef enum logic [TYPE_W-1:0] {
    EV_MANUAL = 2'b00,
    EV_HW     = 2'b01,
    EV_CHAIN  = 2'b10,
    EV_AUTO   = 2'b11
  } evt_kind_e;
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  input  logic [PTR_W-1:0] view_idx,
  output logic [W-1:0]     view_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  // storage without reset, single write port
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head      = mem[rd_ptr];
  assign view_data = mem[rd_ptr + view_idx];
  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(DEPTH)) |-> !push);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> !pop);
  assert_count_range_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/evt_pend_arb.sv
module evt_pend_arb
  import evt_sched_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int NUM_Q  = 4,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int Q_W  = $clog2(NUM_Q)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        evt_set,
  input  logic [NUM_CH*TYPE_W-1:0] evt_type,
  input  logic                     map_we,
  input  logic [CH_W-1:0]          map_ch,
  input  logic [Q_W-1:0]           map_q,
  input  logic [NUM_Q-1:0]         q_full,
  output logic                     win_vld,
  output logic [CH_W-1:0]          win_ch,
  output logic [Q_W-1:0]           win_q,
  output logic [TYPE_W-1:0]        win_type,
  output logic [NUM_CH-1:0]        pend
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] clr_mask;
  logic [Q_W-1:0]    map_r  [NUM_CH];
  logic [TYPE_W-1:0] kind_r [NUM_CH];

  // per-channel queue map and latched type
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        map_r[c]  <= '0;
        kind_r[c] <= '0;
      end
    end else begin
      if (map_we) map_r[map_ch] <= map_q;
      for (int c = 0; c < NUM_CH; c++)
        if (evt_set[c]) kind_r[c] <= evt_type[c*TYPE_W +: TYPE_W];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
      assign elig[c] = pend_q[c] & ~q_full[map_r[c]];
    end
  endgenerate

  // lowest eligible channel wins
  always_comb begin
    win_vld = 1'b0;
    win_ch  = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (elig[c]) begin
        win_vld = 1'b1;
        win_ch  = CH_W'(c);
      end
    end
  end

  assign win_q    = map_r[win_ch];
  assign win_type = kind_r[win_ch];

  always_comb begin
    clr_mask = '0;
    if (win_vld) clr_mask[win_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | evt_set;
  end

  assign pend = pend_q;

  assert_win_pending_R2: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> pend_q[win_ch]);
  assert_win_clears_R1: assert property (@(posedge clk) disable iff (rst)
    (win_vld && !evt_set[win_ch]) |=> !pend_q[$past(win_ch)]);
  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> !q_full[win_q]);
endmodule

// File: rtl/evt_issue.sv
module evt_issue #(
  parameter int NUM_Q = 4,
  parameter int ENT_W = 8,
  localparam int Q_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_Q-1:0]       q_nonempty,
  input  logic [NUM_Q*ENT_W-1:0] q_head,
  input  logic [NUM_Q-1:0]       tc_ready,
  input  logic [NUM_Q-1:0]       tc_idle,
  input  logic                   win_vld,
  input  logic [Q_W-1:0]         win_q,
  input  logic [ENT_W-1:0]       win_entry,
  output logic [NUM_Q-1:0]       pop,
  output logic [NUM_Q-1:0]       push,
  output logic [NUM_Q-1:0]       req_valid,
  output logic [NUM_Q*ENT_W-1:0] req_entry
);
  logic             byp;
  logic [NUM_Q-1:0] byp_hot;

  // fixed priority: lowest ready non-empty queue
  always_comb begin
    pop = '0;
    for (int q = NUM_Q - 1; q >= 0; q--) begin
      if (q_nonempty[q] && tc_ready[q]) begin
        pop    = '0;
        pop[q] = 1'b1;
      end
    end
  end

  assign byp = win_vld && (pop == '0) && !q_nonempty[win_q]
               && tc_idle[win_q] && tc_ready[win_q];

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_route
      assign byp_hot[q] = byp && (win_q == Q_W'(q));
      assign push[q]    = win_vld && !byp && (win_q == Q_W'(q));

      always_ff @(posedge clk) begin
        if (rst) begin
          req_entry[q*ENT_W +: ENT_W] <= '0;
        end else if (pop[q]) begin
          req_entry[q*ENT_W +: ENT_W] <= q_head[q*ENT_W +: ENT_W];
        end else if (byp_hot[q]) begin
          req_entry[q*ENT_W +: ENT_W] <= win_entry;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) req_valid <= '0;
    else     req_valid <= pop | byp_hot;
  end

  assert_one_req_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_valid));
  assert_ready_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (pop & ~tc_ready) == '0);
  assert_bypass_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (byp_hot != '0) |-> ((byp_hot & q_nonempty) == '0));
endmodule

// File: rtl/evt_queue_sched.sv
module evt_queue_sched
  import evt_sched_pkg::*;
#(
  parameter int NUM_CH  = 64,
  parameter int NUM_Q   = 4,
  parameter int Q_DEPTH = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int Q_W   = $clog2(NUM_Q),
  localparam int IDX_W = $clog2(Q_DEPTH),
  localparam int CNT_W = $clog2(Q_DEPTH + 1),
  localparam int ENT_W = TYPE_W + CH_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        evt_set,
  input  logic [NUM_CH*TYPE_W-1:0] evt_type,
  input  logic                     map_we,
  input  logic [CH_W-1:0]          map_ch,
  input  logic [Q_W-1:0]           map_q,
  input  logic [NUM_Q-1:0]         tc_ready,
  input  logic [NUM_Q-1:0]         tc_idle,
  output logic [NUM_Q-1:0]         req_valid,
  output logic [NUM_Q*TYPE_W-1:0]  req_type,
  output logic [NUM_Q*CH_W-1:0]    req_ch,
  input  logic [Q_W-1:0]           view_q,
  input  logic [IDX_W-1:0]         view_idx,
  output logic [ENT_W-1:0]         view_entry,
  output logic                     view_vld,
  output logic [NUM_Q*CNT_W-1:0]   q_count,
  output logic [NUM_CH-1:0]        pend
);
  logic                   win_vld;
  logic [CH_W-1:0]        win_ch;
  logic [Q_W-1:0]         win_q;
  logic [TYPE_W-1:0]      win_type;
  logic [NUM_Q-1:0]       q_full, q_nonempty, pop, push;
  logic [NUM_Q*ENT_W-1:0] q_head, req_entry;
  logic [ENT_W-1:0]       q_view [NUM_Q];
  logic [CNT_W-1:0]       q_cnt  [NUM_Q];

  evt_pend_arb #(.NUM_CH(NUM_CH), .NUM_Q(NUM_Q)) u_arb (
    .clk(clk), .rst(rst), .evt_set(evt_set), .evt_type(evt_type),
    .map_we(map_we), .map_ch(map_ch), .map_q(map_q), .q_full(q_full),
    .win_vld(win_vld), .win_ch(win_ch), .win_q(win_q),
    .win_type(win_type), .pend(pend)
  );

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      evt_fifo #(.DEPTH(Q_DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push[q]),
        .push_data({win_type, win_ch}), .pop(pop[q]),
        .head(q_head[q*ENT_W +: ENT_W]), .count(q_cnt[q]),
        .full(q_full[q]), .view_idx(view_idx), .view_data(q_view[q])
      );
      assign q_nonempty[q] = (q_cnt[q] != '0);
      assign q_count[q*CNT_W +: CNT_W] = q_cnt[q];
      assign req_type[q*TYPE_W +: TYPE_W] = req_entry[q*ENT_W + CH_W +: TYPE_W];
      assign req_ch[q*CH_W +: CH_W]       = req_entry[q*ENT_W +: CH_W];
    end
  endgenerate

  evt_issue #(.NUM_Q(NUM_Q), .ENT_W(ENT_W)) u_issue (
    .clk(clk), .rst(rst), .q_nonempty(q_nonempty), .q_head(q_head),
    .tc_ready(tc_ready), .tc_idle(tc_idle), .win_vld(win_vld),
    .win_q(win_q), .win_entry({win_type, win_ch}), .pop(pop),
    .push(push), .req_valid(req_valid), .req_entry(req_entry)
  );

  // registered read-only entry view
  always_ff @(posedge clk) begin
    if (rst) begin
      view_entry <= '0;
      view_vld   <= 1'b0;
    end else begin
      view_entry <= q_view[view_q];
      view_vld   <= (CNT_W'(view_idx) < q_cnt[view_q]);
    end
  end

  assert_push_mapped_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push));
  assert_single_issue_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(pop) <= 1);
endmodule

// File: tb/test_evt_queue_sched.sv
`timescale 1ns/1ps
module test_evt_queue_sched;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] evt_set;
  logic [127:0] evt_type;
  logic        map_we;
  logic [5:0]  map_ch;
  logic [1:0]  map_q;
  logic [3:0]  tc_ready, tc_idle;
  logic [3:0]  req_valid;
  logic [7:0]  req_type;
  logic [23:0] req_ch;
  logic [1:0]  view_q;
  logic [3:0]  view_idx;
  logic [7:0]  view_entry;
  logic        view_vld;
  logic [19:0] q_count;
  logic [63:0] pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_queue_sched i_evt_queue_sched (
    .clk(clk), .rst(rst), .evt_set(evt_set), .evt_type(evt_type),
    .map_we(map_we), .map_ch(map_ch), .map_q(map_q),
    .tc_ready(tc_ready), .tc_idle(tc_idle), .req_valid(req_valid),
    .req_type(req_type), .req_ch(req_ch), .view_q(view_q),
    .view_idx(view_idx), .view_entry(view_entry), .view_vld(view_vld),
    .q_count(q_count), .pend(pend)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] cnt(input int q);
    return q_count[q*5 +: 5];
  endfunction

  function automatic logic [5:0] rch(input int q);
    return req_ch[q*6 +: 6];
  endfunction

  task automatic do_reset();
    rst = 1'b1; evt_set = '0; evt_type = '0; map_we = 1'b0; map_ch = '0;
    map_q = '0; tc_ready = '0; tc_idle = '0; view_q = '0; view_idx = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic set_map(input int ch, input int q);
    map_we = 1'b1; map_ch = 6'(ch); map_q = 2'(q);
    tick();
    map_we = 1'b0;
  endtask

  task automatic trig(input int ch, input int t);
    evt_set[ch] = 1'b1;
    evt_type[ch*2 +: 2] = 2'(t);
    tick();
    evt_set = '0;
  endtask

  task automatic peek(input int q, input int idx);
    view_q = 2'(q); view_idx = 4'(idx);
    tick();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R11 counts after reset", q_count, 0);
    chk("R11 req_valid after reset", req_valid, 0);
    chk("R11 pend after reset", pend, 0);
    peek(0, 0);
    chk("R9 view_vld on empty queue", view_vld, 0);
  endtask

  task automatic t_bypass();
    do_reset();
    tc_ready = 4'hF; tc_idle = 4'hF;
    trig(5, 1);
    chk("R1 pend set after trigger", pend[5], 1);
    tick();
    chk("R8 bypass request", req_valid, 4'b0001);
    chk("R8 bypass channel", rch(0), 5);
    chk("R9 bypass type", req_type[1:0], 2'b01);
    chk("R8 bypass not counted", cnt(0), 0);
    chk("R1 pend cleared on bypass", pend[5], 0);
    tick();
    chk("R8 single pulse", req_valid, 0);
  endtask

  task automatic t_not_idle();
    do_reset();
    tc_ready = 4'b0001; tc_idle = 4'b0000;
    trig(7, 2);
    tick();
    chk("R8 busy controller queues event", cnt(0), 1);
    chk("R8 no request on enqueue cycle", req_valid, 0);
    tick();
    chk("R6 dequeue request", req_valid, 4'b0001);
    chk("R6 dequeued channel", rch(0), 7);
    chk("R10 count back to zero", cnt(0), 0);
  endtask

  task automatic t_map_view();
    do_reset();
    set_map(9, 2);
    trig(9, 3);
    tick();
    chk("R3 mapped queue count", cnt(2), 1);
    chk("R3 queue 0 untouched", cnt(0), 0);
    chk("R6 no request when not ready", req_valid, 0);
    peek(2, 0);
    chk("R9 entry encoding", view_entry, 8'hC9);
    chk("R9 entry valid", view_vld, 1);
    peek(2, 1);
    chk("R9 index past fill invalid", view_vld, 0);
  endtask

  task automatic t_order();
    do_reset();
    evt_set[3] = 1'b1; evt_type[7:6] = 2'b10;
    evt_set[1] = 1'b1; evt_type[3:2] = 2'b00;
    tick();
    evt_set = '0;
    tick();
    chk("R2 lowest channel taken first", pend[3:0], 4'b1000);
    tick();
    chk("R2 one per cycle, both queued", cnt(0), 2);
    peek(0, 0);
    chk("R5 head entry", view_entry, 8'h01);
    peek(0, 1);
    chk("R5 second entry", view_entry, 8'h83);
    tc_ready = 4'b0001;
    tick();
    chk("R5 first issued", rch(0), 1);
    tick();
    chk("R5 second issued", rch(0), 3);
    chk("R9 second type", req_type[1:0], 2'b10);
    tc_ready = '0;
  endtask

  task automatic t_priority();
    do_reset();
    set_map(4, 1);
    evt_set[4] = 1'b1; evt_set[2] = 1'b1;
    tick();
    evt_set = '0;
    tick(); tick();
    chk("R3 queue 1 holds ch4", cnt(1), 1);
    tc_ready = 4'b0011;
    tick();
    chk("R7 lowest queue served first", req_valid, 4'b0001);
    chk("R7 queue 0 channel", rch(0), 2);
    tick();
    chk("R7 queue 1 next cycle", req_valid, 4'b0010);
    chk("R6 queue 1 channel", rch(1), 4);
    tick();
    chk("R7 nothing left", req_valid, 0);
    tc_ready = '0;
  endtask

  task automatic t_full();
    logic [63:0] exp_p;
    do_reset();
    for (int c = 10; c <= 26; c++) set_map(c, 3);
    for (int c = 10; c <= 26; c++) evt_set[c] = 1'b1;
    tick();
    evt_set = '0;
    for (int i = 0; i < 20; i++) tick();
    exp_p = '0; exp_p[26] = 1'b1;
    chk("R4 queue caps at 16", cnt(3), 16);
    chk("R4 overflow event stays pending", pend, exp_p);
    peek(3, 15);
    chk("R5 tail entry", view_entry, 8'd25);
    tc_ready = 4'b1000;
    tick();
    tc_ready = '0;
    chk("R6 first out of full queue", rch(3), 10);
    chk("R10 count after one pop", cnt(3), 15);
    tick();
    chk("R4 pending event taken after space", pend, 0);
    chk("R10 back to full", cnt(3), 16);
    peek(3, 15);
    chk("R4 late event at tail", view_entry, 8'd26);
  endtask

  task automatic t_reset_mid();
    do_reset();
    set_map(9, 2);
    trig(9, 0); tick();
    trig(11, 0);
    rst = 1'b1; tick(); rst = 1'b0; tick();
    chk("R11 queues emptied", q_count, 0);
    chk("R11 pending cleared", pend, 0);
    trig(9, 0); tick();
    chk("R11 map returns to queue 0", cnt(0), 1);
  endtask

  initial begin
    t_reset_state();
    t_bypass();
    t_not_idle();
    t_map_view();
    t_order();
    t_priority();
    t_full();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule